// File: doc/BRIEF.md
# Single-Wire Debug Link Receive Front End

This block sits on the target side of a half-duplex debug port that shares one open-drain data line with an external host. It oversamples the line, rebuilds each byte frame (a low start bit, eight data bits least significant first, a parity bit and a high stop bit), and classifies the frame. A frame whose parity bit is zero counts as acknowledged. This lets a live host be told apart from an idle line that reads as all ones. The frame has a framing error if its stop bit is low. The host produces a start bit by sending the all-ones character, so only the start bit is low.

The command stream is closed after reset. Every byte is thrown away until the read-revision opcode arrives in an acknowledged frame. That byte opens the link. It is strobed out with a marker which tells the downstream decoder that no packet CRC follows this opening command. After that, each acknowledged byte is strobed out as a command byte. If the link opens while the target reset input is held, the halt bit of the debug control register is set and stays set. When target reset is asserted again, the link closes and the read-revision command must arrive once more.

Top module: `swl_front`

## Requirements
- R1: A frame is a low start bit, data bits 0 to 7 in that order, a parity bit and a stop bit, each BIT_CLKS clock cycles long. Each bit is sampled at the middle of its period, and a received byte is reproduced on cmd_o with bit 0 first on the line.
- R2: A low pulse that is high again at the midpoint of the start bit is discarded. It produces no cmd_valid_o, frame_err_o or nack_o pulse, and a following frame is still received correctly.
- R3: A frame whose stop bit is sampled low gives a one-cycle frame_err_o pulse and no cmd_valid_o or nack_o pulse.
- R4: A frame with a high stop bit and parity bit 1 gives a one-cycle nack_o pulse and no cmd_valid_o. A frame with parity bit 0 counts as acknowledged.
- R5: While link_open_o is low, acknowledged bytes other than REV_OP, including the all-ones character 0xFF, give no cmd_valid_o, and link_open_o stays low.
- R6: While the link is closed, an acknowledged byte equal to REV_OP sets link_open_o. It also gives one cmd_valid_o pulse with cmd_o = REV_OP and open_cmd_o = 1, which marks a command that has no trailing CRC.
- R7: While the link is open, each acknowledged byte, REV_OP included, gives one cmd_valid_o pulse with that byte on cmd_o and open_cmd_o = 0.
- R8: halt_o is set when the link opens while tgt_reset_i is 1. Opening while tgt_reset_i is 0 leaves halt_o at 0.
- R9: Once set, halt_o stays 1 until rst_n is asserted, whatever tgt_reset_i and the line do.
- R10: A 0-to-1 change of tgt_reset_i clears link_open_o. Bytes that follow are then discarded until REV_OP arrives again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset of the block |
| tgt_reset_i | input | 1 | Target reset, 1 while reset is held |
| line_i | input | 1 | Level of the shared single-wire data line |
| cmd_o | output | 8 | Received command byte |
| cmd_valid_o | output | 1 | One-cycle strobe for cmd_o |
| open_cmd_o | output | 1 | With the strobe: this is the opening read-revision byte, no CRC follows |
| link_open_o | output | 1 | Command stream is open |
| halt_o | output | 1 | Halt bit of the debug control register |
| frame_err_o | output | 1 | One-cycle pulse: stop bit was low |
| nack_o | output | 1 | One-cycle pulse: parity bit was 1 (no acknowledge) |

## Verification
The bench builds the block with BIT_CLKS = 8, SYNC_STAGES = 2 and REV_OP = 8'h00. The short bit period keeps each frame near a hundred cycles, and it still leaves a half period of four cycles. A two-cycle low pulse therefore falls clearly inside the glitch window. An all-zero opening opcode is the opposite extreme of the 0xFF start character, so the opening path is tested with the data line held low for the whole byte. Alternating patterns such as 0xA5 and 0x5A show the bit order.

// File: rtl/swl_pkg.sv
package swl_pkg;
   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PAR,
      RX_STOP
   } rx_state_t;

   typedef struct packed {
      logic [7:0] data;
      logic       parity;
      logic       stop_ok;
   } rx_frame_t;
endpackage

// File: rtl/swl_sync.sv
module swl_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], d_i} & {STAGES{1'b1}};
         end
         assign q_o = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/swl_frame_rx.sv
module swl_frame_rx
   import swl_pkg::*;
#(
   parameter int BIT_CLKS = 16
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      line_i,
   output logic      done_o,
   output rx_frame_t frame_o
);
   localparam int CW   = $clog2(BIT_CLKS);
   localparam int HALF = BIT_CLKS / 2;
   localparam logic [CW-1:0] RELOAD_FULL = CW'(BIT_CLKS - 1);
   localparam logic [CW-1:0] RELOAD_HALF = CW'(HALF - 1);

   rx_state_t     state_q;
   logic [CW-1:0] cnt_q;
   logic [2:0]    idx_q;
   logic [7:0]    shift_q;
   logic          par_q;
   logic          prev_q;
   logic          tick;

   assign tick = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RX_IDLE;
         cnt_q   <= '0;
         idx_q   <= '0;
         shift_q <= '0;
         par_q   <= 1'b0;
         prev_q  <= 1'b1;
         done_o  <= 1'b0;
         frame_o <= '0;
      end else begin
         done_o <= 1'b0;
         prev_q <= line_i;
         if (state_q != RX_IDLE && !tick) cnt_q <= cnt_q - 1'b1;
         case (state_q)
            RX_IDLE: begin
               if (prev_q && !line_i) begin
                  state_q <= RX_START;
                  cnt_q   <= RELOAD_HALF;
               end
            end
            RX_START: begin
               if (tick) begin
                  if (!line_i) begin
                     state_q <= RX_DATA;
                     cnt_q   <= RELOAD_FULL;
                     idx_q   <= '0;
                  end else begin
                     state_q <= RX_IDLE;
                  end
               end
            end
            RX_DATA: begin
               if (tick) begin
                  shift_q <= {line_i, shift_q[7:1]};
                  cnt_q   <= RELOAD_FULL;
                  if (idx_q == 3'd7) state_q <= RX_PAR;
                  else               idx_q   <= idx_q + 1'b1;
               end
            end
            RX_PAR: begin
               if (tick) begin
                  par_q   <= line_i;
                  cnt_q   <= RELOAD_FULL;
                  state_q <= RX_STOP;
               end
            end
            RX_STOP: begin
               if (tick) begin
                  frame_o <= '{data: shift_q, parity: par_q, stop_ok: line_i};
                  done_o  <= 1'b1;
                  state_q <= RX_IDLE;
               end
            end
            default: state_q <= RX_IDLE;
         endcase
      end
   end

   AST_DONE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(state_q) == RX_STOP) else $error("done without stop"); // R1
endmodule

// File: rtl/swl_link_gate.sv
module swl_link_gate
   import swl_pkg::*;
#(
   parameter logic [7:0] REV_OP = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tgt_reset_i,
   input  logic       done_i,
   input  rx_frame_t  frame_i,
   output logic [7:0] cmd_o,
   output logic       cmd_valid_o,
   output logic       open_cmd_o,
   output logic       link_open_o,
   output logic       halt_o,
   output logic       frame_err_o,
   output logic       nack_o
);
   logic rst_prev_q;
   logic reset_rise;
   logic is_rev;

   assign reset_rise = tgt_reset_i && !rst_prev_q;
   assign is_rev     = (frame_i.data == REV_OP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_prev_q  <= 1'b0;
         cmd_o       <= '0;
         cmd_valid_o <= 1'b0;
         open_cmd_o  <= 1'b0;
         link_open_o <= 1'b0;
         halt_o      <= 1'b0;
         frame_err_o <= 1'b0;
         nack_o      <= 1'b0;
      end else begin
         rst_prev_q  <= tgt_reset_i;
         cmd_valid_o <= 1'b0;
         open_cmd_o  <= 1'b0;
         frame_err_o <= 1'b0;
         nack_o      <= 1'b0;
         if (reset_rise) begin
            link_open_o <= 1'b0;
         end else if (done_i) begin
            if (!frame_i.stop_ok) begin
               frame_err_o <= 1'b1;
            end else if (frame_i.parity) begin
               nack_o <= 1'b1;
            end else if (!link_open_o) begin
               if (is_rev) begin
                  link_open_o <= 1'b1;
                  cmd_valid_o <= 1'b1;
                  open_cmd_o  <= 1'b1;
                  cmd_o       <= frame_i.data;
                  if (tgt_reset_i) halt_o <= 1'b1;
               end
            end else begin
               cmd_valid_o <= 1'b1;
               cmd_o       <= frame_i.data;
            end
         end
      end
   end

   AST_STROBE_WHILE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_o |-> link_open_o) else $error("strobe while closed"); // R5
   AST_OPEN_CMD_IS_REV: assert property (@(posedge clk) disable iff (!rst_n)
      open_cmd_o |-> (cmd_valid_o && cmd_o == REV_OP)) else $error("bad opening"); // R6
   AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd_valid_o, frame_err_o, nack_o})) else $error("events overlap"); // R3
   AST_HALT_NEEDS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halt_o) |-> $past(tgt_reset_i)) else $error("halt without reset"); // R8
   AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      halt_o |=> halt_o) else $error("halt dropped"); // R9
   AST_RESET_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tgt_reset_i) |=> !link_open_o) else $error("link stayed open"); // R10
endmodule

// File: rtl/swl_front.sv
module swl_front
   import swl_pkg::*;
#(
   parameter int         BIT_CLKS    = 16,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] REV_OP      = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tgt_reset_i,
   input  logic       line_i,
   output logic [7:0] cmd_o,
   output logic       cmd_valid_o,
   output logic       open_cmd_o,
   output logic       link_open_o,
   output logic       halt_o,
   output logic       frame_err_o,
   output logic       nack_o
);
   generate
      if (BIT_CLKS < 4) begin : g_bad_bit
         $error("BIT_CLKS must be at least 4");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 to 3");
      end
   endgenerate

   logic      line_s;
   logic      done;
   rx_frame_t frame;

   swl_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(line_i), .q_o(line_s)
   );

   swl_frame_rx #(.BIT_CLKS(BIT_CLKS)) u_rx (
      .clk(clk), .rst_n(rst_n), .line_i(line_s), .done_o(done), .frame_o(frame)
   );

   swl_link_gate #(.REV_OP(REV_OP)) u_gate (
      .clk(clk), .rst_n(rst_n), .tgt_reset_i(tgt_reset_i),
      .done_i(done), .frame_i(frame),
      .cmd_o(cmd_o), .cmd_valid_o(cmd_valid_o), .open_cmd_o(open_cmd_o),
      .link_open_o(link_open_o), .halt_o(halt_o),
      .frame_err_o(frame_err_o), .nack_o(nack_o)
   );
endmodule

// File: tb/tb_swl_front.sv
`timescale 1ns/1ps
module tb_swl_front;
   localparam int         BIT = 8;
   localparam logic [7:0] REV = 8'h00;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tgt_reset = 1'b0;
   logic line = 1'b1;
   logic [7:0] cmd;
   logic cmd_valid, open_cmd, link_open, halt, frame_err, nack;

   int errors = 0;
   int checks = 0;
   int n_valid = 0, n_ferr = 0, n_nack = 0;
   logic [7:0] last_cmd = 8'h00;
   logic last_open = 1'b0;

   always #2.5 clk = ~clk;

   swl_front #(.BIT_CLKS(BIT), .SYNC_STAGES(2), .REV_OP(REV)) dut (
      .clk(clk), .rst_n(rst_n), .tgt_reset_i(tgt_reset), .line_i(line),
      .cmd_o(cmd), .cmd_valid_o(cmd_valid), .open_cmd_o(open_cmd),
      .link_open_o(link_open), .halt_o(halt),
      .frame_err_o(frame_err), .nack_o(nack)
   );

   always @(negedge clk) begin
      if (cmd_valid) begin
         n_valid   <= n_valid + 1;
         last_cmd  <= cmd;
         last_open <= open_cmd;
      end
      if (frame_err) n_ferr <= n_ferr + 1;
      if (nack)      n_nack <= n_nack + 1;
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send_frame(input logic [7:0] b, input logic par, input logic stop);
      @(negedge clk) line = 1'b0;
      repeat (BIT) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         line = b[i];
         repeat (BIT) @(negedge clk);
      end
      line = par;
      repeat (BIT) @(negedge clk);
      line = stop;
      repeat (BIT) @(negedge clk);
      line = 1'b1;
      repeat (3 * BIT) @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      tgt_reset = 1'b0;
      line = 1'b1;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check("R9 reset halt", halt, 0);
      check("R5 reset closed", link_open, 0);
      check("R1 reset no strobe", cmd_valid, 0);
   endtask

   task automatic t_closed_discard();
      int v0 = n_valid;
      send_frame(8'hFF, 1'b0, 1'b1);
      send_frame(8'h3C, 1'b0, 1'b1);
      check("R5 closed bytes dropped", n_valid - v0, 0);
      check("R5 link stays closed", link_open, 0);
   endtask

   task automatic t_open_in_reset();
      int v0 = n_valid;
      tgt_reset = 1'b1;
      repeat (4) @(negedge clk);
      send_frame(8'hFF, 1'b0, 1'b1);
      send_frame(REV, 1'b0, 1'b1);
      check("R6 opening strobe", n_valid - v0, 1);
      check("R6 opening byte", last_cmd, REV);
      check("R6 opening no-CRC mark", last_open, 1);
      check("R6 link open", link_open, 1);
      check("R8 halt set in reset", halt, 1);
   endtask

   task automatic t_commands();
      int v0 = n_valid;
      send_frame(8'hA5, 1'b0, 1'b1);
      check("R1 byte A5", last_cmd, 8'hA5);
      check("R7 mark clear", last_open, 0);
      send_frame(8'h5A, 1'b0, 1'b1);
      check("R1 byte 5A", last_cmd, 8'h5A);
      send_frame(REV, 1'b0, 1'b1);
      check("R7 REV passed as command", last_open, 0);
      check("R7 strobe count", n_valid - v0, 3);
   endtask

   task automatic t_nack();
      int v0 = n_valid, k0 = n_nack;
      send_frame(8'h42, 1'b1, 1'b1);
      check("R4 nack pulse", n_nack - k0, 1);
      check("R4 no strobe on nack", n_valid - v0, 0);
   endtask

   task automatic t_ferr();
      int v0 = n_valid, f0 = n_ferr, k0 = n_nack;
      send_frame(8'h81, 1'b0, 1'b0);
      check("R3 frame error pulse", n_ferr - f0, 1);
      check("R3 no strobe", n_valid - v0, 0);
      check("R3 no nack", n_nack - k0, 0);
   endtask

   task automatic t_glitch();
      int v0 = n_valid, f0 = n_ferr, k0 = n_nack;
      @(negedge clk) line = 1'b0;
      repeat (2) @(negedge clk);
      line = 1'b1;
      repeat (14 * BIT) @(negedge clk);
      check("R2 glitch no strobe", n_valid - v0, 0);
      check("R2 glitch no events", (n_ferr - f0) + (n_nack - k0), 0);
      send_frame(8'h3E, 1'b0, 1'b1);
      check("R2 frame after glitch", last_cmd, 8'h3E);
   endtask

   task automatic t_reclose();
      int v0;
      tgt_reset = 1'b0;
      repeat (4) @(negedge clk);
      check("R9 halt held after release", halt, 1);
      tgt_reset = 1'b1;
      repeat (4) @(negedge clk);
      check("R10 link closed", link_open, 0);
      v0 = n_valid;
      send_frame(8'h11, 1'b0, 1'b1);
      check("R10 byte dropped", n_valid - v0, 0);
      send_frame(REV, 1'b0, 1'b1);
      check("R10 reopened", link_open, 1);
      check("R10 reopen mark", last_open, 1);
   endtask

   task automatic t_open_no_halt();
      do_reset();
      send_frame(REV, 1'b0, 1'b1);
      check("R8 open outside reset", link_open, 1);
      check("R8 no halt", halt, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      do_reset();
      t_closed_discard();
      t_open_in_reset();
      t_commands();
      t_nack();
      t_ferr();
      t_glitch();
      t_reclose();
      t_open_no_halt();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule